// File: doc/BRIEF.md
# Comparator Status and Interrupt Selector

This block collects the comparator outputs of up to four analog columns and shows them to a CPU as read-only status bits in one byte-wide register. Each column also drives a two-phase column clock. The block samples the comparator of a column only on the falling edge of that column's second clock phase. A poll therefore returns a value that is settled and aligned to the column clock. All inputs are brought into the CPU clock domain through a parameterised flop synchronizer first, so the whole block runs on a single clock.

The same register holds one writable select bit per column. That bit picks what drives the column's interrupt request line. With the bit clear, a captured comparator transition from low to high raises a request. With the bit set, every falling edge of the column's second clock phase raises a request, so firmware can lock onto the column clock. Each request is a registered pulse one CPU cycle wide.

The column count is a parameter from 1 to 4. Bits that belong to columns which are not built read as zero.

Top module: `cmpirq_top`

## Requirements
- R1: While reset is high and on the cycle after, the register image is 0x00 and every interrupt line is low, so comparator-sourced interrupts are selected after reset.
- R2: Register bit 4+c holds column c's comparator value as captured on the most recent falling edge of that column's second clock phase. A comparator change with no such edge does not alter the bit.
- R3: Writes never change bits 7:4. Only the status capture of R2 updates them.
- R4: Bit c of the register (c below the column count) is a select bit for column c. It is written from write-data bit c and reads back the value written.
- R5: With the select bit at 0, a column gives exactly one interrupt pulse for each capture in which its status goes from 0 to 1. A capture from 1 to 0, or with the value unchanged, gives none.
- R6: With the select bit at 1, a column gives exactly one interrupt pulse for each falling edge of its second clock phase, whatever the comparator does.
- R7: Every interrupt pulse is high for exactly one CPU clock cycle.
- R8: For columns at or above the column count, both the status bit and the select bit read as 0.
- R9: The register answers only at address 0x64. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R10: Read data is registered. It shows the register image in the cycle after a read strobe and 0x00 in any cycle that does not follow a read strobe.
- R11: A change of a select bit applies to the clock-phase edges and comparator captures that come after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | NUM_COLS | Raw comparator output per column |
| phi2_i | input | NUM_COLS | Second clock phase per column |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | NUM_COLS | One-cycle interrupt request per column |

## Verification
The bench moves the comparator while the clock phase stays still, and checks that the status does not move. A design that sampled the comparator freely would fail this. It holds the comparator high over several phase edges, and then drops it. A design that edge-detected the raw input, or that treated a level as an event, would give extra or missing pulses. It flips a select bit between two phase edges and counts pulses on each side of the write. It also writes ones into the status field, writes to a neighbouring address, and checks a two-column build for its zeroed upper fields. These catch a design that leaks writes or decodes the address loosely.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  localparam int unsigned MAX_COLS = 4;
  localparam int unsigned REG_W    = 8;

  // Register image: status in the upper nibble, select in the lower.
  typedef struct packed {
    logic [MAX_COLS-1:0] stat;
    logic [MAX_COLS-1:0] sel;
  } ctrl_reg_t;
endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cmpirq_column.sv
module cmpirq_column (
  input  logic clk,
  input  logic rst,
  input  logic cmp_s_i,
  input  logic phi2_s_i,
  input  logic sel_i,
  output logic stat_o,
  output logic irq_o
);
  logic phi2_d_q;
  logic stat_q;
  logic irq_q;
  logic phi2_fall;
  logic cmp_rise;

  assign phi2_fall = phi2_d_q & ~phi2_s_i;
  assign cmp_rise  = phi2_fall & cmp_s_i & ~stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_d_q <= 1'b0;
      stat_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      phi2_d_q <= phi2_s_i;
      if (phi2_fall) stat_q <= cmp_s_i;
      irq_q <= sel_i ? phi2_fall : cmp_rise;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_status_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !phi2_fall |=> $stable(stat_q));
  assert_irq_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(phi2_fall));
  assert_cmp_irq_high_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !$past(sel_i)) |-> $past(cmp_s_i));
endmodule

// File: rtl/cmpirq_regs.sv
module cmpirq_regs
  import cmpirq_pkg::*;
#(
  parameter int unsigned      NUM_COLS = 4,
  parameter int unsigned      ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic                rd_i,
  input  logic [NUM_COLS-1:0] stat_i,
  output logic [NUM_COLS-1:0] sel_o,
  output logic [REG_W-1:0]    rdata_o
);
  logic                hit;
  logic [NUM_COLS-1:0] sel_q;
  logic [REG_W-1:0]    rdata_q;
  ctrl_reg_t           image;

  assign hit = (addr_i == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_i && hit) begin
      sel_q <= wdata_i[NUM_COLS-1:0];
    end
  end

  always_comb begin
    image = '0;
    for (int c = 0; c < int'(NUM_COLS); c++) begin
      image.stat[c] = stat_i[c];
      image.sel[c]  = sel_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= (rd_i && hit) ? image : '0;
  end

  assign sel_o   = sel_q;
  assign rdata_o = rdata_q;

  assert_rdata_miss_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !hit) |=> (rdata_q == '0));
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0));
  assert_sel_miss_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && hit) |=> $stable(sel_q));
endmodule

// File: rtl/cmpirq_top.sv
module cmpirq_top
  import cmpirq_pkg::*;
#(
  parameter int unsigned      NUM_COLS    = 4,
  parameter int unsigned      ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h64,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_COLS-1:0] cmp_i,
  input  logic [NUM_COLS-1:0] phi2_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  input  logic                reg_rd_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic [NUM_COLS-1:0] irq_o
);
  localparam int unsigned SYNC_W = 2 * NUM_COLS;

  logic [SYNC_W-1:0]   raw_in;
  logic [SYNC_W-1:0]   sync_out;
  logic [NUM_COLS-1:0] cmp_s;
  logic [NUM_COLS-1:0] phi2_s;
  logic [NUM_COLS-1:0] stat;
  logic [NUM_COLS-1:0] sel;

  assign raw_in = {phi2_i, cmp_i};

  cmpirq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (sync_out)
  );

  assign cmp_s  = sync_out[NUM_COLS-1:0];
  assign phi2_s = sync_out[SYNC_W-1:NUM_COLS];

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    cmpirq_column u_col (
      .clk      (clk),
      .rst      (rst),
      .cmp_s_i  (cmp_s[c]),
      .phi2_s_i (phi2_s[c]),
      .sel_i    (sel[c]),
      .stat_o   (stat[c]),
      .irq_o    (irq_o[c])
    );
  end

  cmpirq_regs #(.NUM_COLS(NUM_COLS), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .rd_i    (reg_rd_i),
    .stat_i  (stat),
    .sel_o   (sel),
    .rdata_o (reg_rdata_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> ((irq_o == '0) && (reg_rdata_o == '0)));
endmodule

// File: tb/cmpirq_top_tb_top.sv
module cmpirq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmp = '0;
  logic [3:0] phi2 = '0;
  logic [7:0] addr = 8'h64;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic [3:0] irq;
  logic [7:0] rdata2;
  logic [1:0] irq2;

  int checks = 0;
  int errors = 0;
  int cnt [4];
  int dbl = 0;
  logic [3:0] irq_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpirq_top dut_i (
    .clk(clk), .rst(rst), .cmp_i(cmp), .phi2_i(phi2),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  cmpirq_top #(.NUM_COLS(2)) dut_n2_i (
    .clk(clk), .rst(rst), .cmp_i(cmp[1:0]), .phi2_i(phi2[1:0]),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata2), .irq_o(irq2)
  );

  initial for (int c = 0; c < 4; c++) cnt[c] = 0;

  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 4; c++) if (irq[c]) cnt[c]++;
      if ((irq & irq_prev) != 0) dbl++;
    end
    irq_prev = irq;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 8'h64;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [7:0] d, output logic [7:0] d2);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; addr = 8'h64; d = rdata; d2 = rdata2;
  endtask

  task automatic phi2_cycle();
    @(negedge clk); phi2 = 4'hF;
    repeat (5) @(negedge clk);
    phi2 = 4'h0;
    repeat (7) @(negedge clk);
  endtask

  task automatic snap(output int b [4]);
    for (int c = 0; c < 4; c++) b[c] = cnt[c];
  endtask

  task automatic t_reset();
    logic [7:0] d, d2;
    check("R1 rdata in reset", int'(rdata), 0);
    check("R1 irq in reset", int'(irq), 0);
    @(negedge clk); rst = 1'b0;
    reg_read(8'h64, d, d2);
    check("R1 image after reset", int'(d), 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d, d2;
    cmp = 4'b1010;
    repeat (8) @(negedge clk);
    reg_read(8'h64, d, d2);
    check("R2 no capture without phase edge", int'(d), 8'h00);
    phi2_cycle();
    reg_read(8'h64, d, d2);
    check("R2 captured status", int'(d), 8'hA0);
    cmp = 4'b0101;
    repeat (8) @(negedge clk);
    reg_read(8'h64, d, d2);
    check("R2 status held between edges", int'(d), 8'hA0);
  endtask

  task automatic t_readonly();
    logic [7:0] d, d2;
    reg_write(8'h64, 8'hF0);
    reg_read(8'h64, d, d2);
    check("R3 status write ignored", int'(d), 8'hA0);
  endtask

  task automatic t_select_rw();
    logic [7:0] d, d2;
    reg_write(8'h64, 8'h05);
    reg_read(8'h64, d, d2);
    check("R4 select readback", int'(d), 8'hA5);
    @(negedge clk);
    check("R10 idle read data zero", int'(rdata), 0);
    reg_write(8'h64, 8'h00);
  endtask

  task automatic t_address();
    logic [7:0] d, d2;
    reg_write(8'h65, 8'h0F);
    reg_read(8'h64, d, d2);
    check("R9 foreign write ignored", int'(d), 8'hA0);
    reg_read(8'h65, d, d2);
    check("R9 foreign read zero", int'(d), 0);
  endtask

  task automatic t_cmp_irq();
    int b [4];
    cmp = 4'h0; phi2_cycle();
    snap(b);
    cmp = 4'hF; phi2_cycle();
    for (int c = 0; c < 4; c++) check("R5 one pulse per rise", cnt[c] - b[c], 1);
    snap(b);
    phi2_cycle();
    check("R5 no pulse while steady high", cnt[0] - b[0], 0);
    snap(b);
    cmp = 4'h0; phi2_cycle();
    check("R5 no pulse on fall", cnt[3] - b[3], 0);
  endtask

  task automatic t_phase_irq();
    int b [4];
    reg_write(8'h64, 8'h0F);
    snap(b);
    cmp = 4'hF; phi2_cycle();
    cmp = 4'h0; phi2_cycle();
    phi2_cycle();
    for (int c = 0; c < 4; c++) check("R6 pulse per phase edge", cnt[c] - b[c], 3);
    reg_write(8'h64, 8'h00);
  endtask

  task automatic t_sel_change();
    int b [4];
    snap(b);
    phi2_cycle();
    check("R11 no pulse before select", cnt[0] - b[0], 0);
    reg_write(8'h64, 8'h01);
    snap(b);
    phi2_cycle(); phi2_cycle();
    check("R11 col0 follows new select", cnt[0] - b[0], 2);
    check("R11 col1 unaffected", cnt[1] - b[1], 0);
    reg_write(8'h64, 8'h00);
    snap(b);
    phi2_cycle();
    check("R11 select cleared", cnt[0] - b[0], 0);
  endtask

  task automatic t_narrow();
    logic [7:0] d, d2;
    cmp = 4'hF; phi2_cycle();
    reg_write(8'h64, 8'hFF);
    reg_read(8'h64, d, d2);
    check("R8 two-column image", int'(d2), 8'h33);
    check("R8 four-column image", int'(d), 8'hFF);
    reg_write(8'h64, 8'h00);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_status();
    t_readonly();
    t_select_rw();
    t_address();
    t_cmp_irq();
    t_phase_irq();
    t_sel_change();
    t_narrow();
    check("R7 single-cycle pulses", dbl, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule